// File: doc/BRIEF.md
# Frame-Paced Brightness Transition Controller

This block hides the jump in display brightness that would otherwise appear when the active illumination bin changes. Each bin is a light sequence with its own duty-cycle brightness. The block receives a frame-start strobe, a transition length in frames, a bin-select write that carries the target index, a flat table of per-bin brightness values, and a flag that marks static-image display. It drives the active bin index and a digital contrast gain for each frame, in unsigned Q1.15 where 0x8000 is unity.

When brightness must fall, the old bin stays on screen. The gain falls frame by frame toward the ratio of the new brightness to the old, and on the last frame the bin switches with the gain back at unity. When brightness must rise, the bin switches on the first frame with the gain at the ratio of old to new. The gain then climbs to unity. Both the ratio and the per-frame step come from one shared restoring divider, which runs between the select write and the next frame strobe.

The length and select writes are single-cycle strobes with no back-pressure: every write is taken in the cycle it is presented. A select write must lead the frame strobe that begins its transition by at least 40 clock cycles. Otherwise the start moves to a later strobe.

Top module: `bright_xfade`

## Requirements
- R1: After a synchronous active-low reset, the active bin is 0, the gain is 0x8000, busy is low and the stored length is 1.
- R2: The active bin and the gain change only on a clock edge where the frame strobe is high and no select write is present. A strobe in the same cycle as a select write does not count as a frame. Busy rises on the edge of the select write.
- R3: The transition length in force is the value stored when the select write arrives. A length written later applies only to later selects.
- R4: Decrease (target brightness below source). Let r = floor(small*32768/large) and d = floor((32768-r)/N). On transition frame k (1..N-1) the source bin stays active with gain 32768-d*k. On frame N the target bin becomes active with gain 0x8000.
- R5: Increase (target brightness above source). Let d = floor((32768-r)/(N-1)). On frame 1 the target bin becomes active with gain r. On frame k the gain is r+d*(k-1). On frame N the gain is 0x8000.
- R6: A length of 0 or 1 applies the target bin with gain 0x8000 on the first transition frame.
- R7: When the source and target bins have equal brightness, the target is applied on the first transition frame with gain 0x8000.
- R8: If the static-image flag is high on the first transition frame, the target is applied in one step with gain 0x8000, whatever the length.
- R9: A select write while busy stops the ramp. The next frame makes the previously selected target active with gain 0x8000 and keeps busy high. The new transition, whose source is that bin, begins on the frame after.
- R10: For a select write that is not busy, the first frame of its transition is the first counted strobe after the write.
- R11: Busy stays high from the select write until the frame that applies the final bin and unity gain, and it falls only with the gain at 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle frame-start strobe |
| len_wr | input | 1 | Write strobe for the transition length |
| len_data | input | LW (8) | Transition length in frames |
| sel_wr | input | 1 | Bin-select write; starts a transition |
| sel_idx | input | IW (2) | Target bin index |
| bright_tbl | input | BINS*BW (64) | Brightness per bin; bin i at bits [i*BW +: BW] |
| static_mode | input | 1 | High while a static image is shown |
| active_bin | output | IW (2) | Bin currently displayed |
| gain | output | 16 | Contrast gain, Q1.15, 0x8000 = 1.0 |
| busy | output | 1 | Transition pending or running |

## Verification
A stale or wrong ratio or step shows up as a wrong gain on the very first transition frame. Because each frame adds to the gain from the previous one, the error then grows on every later frame. A wrong frame counter or stored length moves the frame on which the bin switches and busy falls. A missed snap leaves the old bin or a non-unity gain on the frame after a mid-ramp select. The bench checks the outputs against a behavioural model on every clock, so each such fault is reported within one frame of its cause.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int GAIN_W = 16;
  localparam logic [GAIN_W-1:0] GAIN_ONE = 16'h8000;

  typedef enum logic [1:0] {
    PL_IDLE,
    PL_RATIO,
    PL_STEP,
    PL_READY
  } plan_ph_e;
endpackage

// File: rtl/bx_divider.sv
// Restoring divider: one quotient bit per cycle, QW cycles per operation.
// Precondition: upper half of the dividend is below the divisor.
module bx_divider #(
  parameter int QW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            done,
  output logic [QW-1:0]   quot
);
  localparam int CW = $clog2(QW + 1);

  logic [QW-1:0] rem_q, lo_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [QW:0]   trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem_q, lo_q[QW-1]};
    ge    = trial >= {1'b0, divisor};
    diff  = trial - {1'b0, divisor};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      lo_q  <= '0;
      quot  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= dividend[2*QW-1:QW];
        lo_q  <= dividend[QW-1:0];
        quot  <= '0;
        cnt_q <= CW'(QW);
        act_q <= 1'b1;
      end else if (act_q) begin
        rem_q <= ge ? diff[QW-1:0] : trial[QW-1:0];
        lo_q  <= lo_q << 1;
        quot  <= {quot[QW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          act_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  AST_DIV_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (dividend[2*QW-1:QW] < divisor)); // R4
endmodule

// File: rtl/bx_planner.sv
// Captures a select write, then computes ratio and per-frame step.
module bx_planner
  import bx_pkg::*;
#(
  parameter int BINS = 4,
  parameter int BW   = 16,
  parameter int LW   = 8,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr,
  input  logic [IW-1:0]      sel_idx,
  input  logic               len_wr,
  input  logic [LW-1:0]      len_data,
  input  logic [BINS*BW-1:0] bright_tbl,
  input  logic               take,
  output logic               ready,
  output logic [IW-1:0]      tgt,
  output logic [LW-1:0]      n_len,
  output logic               dec,
  output logic               imm,
  output logic [GAIN_W-1:0]  ratio,
  output logic [GAIN_W-1:0]  step
);
  localparam int QW = GAIN_W;

  logic [LW-1:0]   len_q;
  logic [BW-1:0]   src_b, tgt_b, lo_b, hi_b;
  logic [IW-1:0]   cur_q;
  plan_ph_e        ph;
  logic            kick, waiting;
  logic            div_start, div_done;
  logic [2*QW-1:0] div_num;
  logic [QW-1:0]   div_den, div_q;

  always_comb begin
    dec  = tgt_b < src_b;
    lo_b = dec ? tgt_b : src_b;
    hi_b = dec ? src_b : tgt_b;
    imm  = (src_b == tgt_b) || (n_len <= LW'(1));
    if (ph == PL_STEP) begin
      div_num = (2*QW)'(GAIN_ONE - ratio);
      div_den = dec ? QW'(n_len) : QW'(n_len - 1'b1);
    end else begin
      div_num = (2*QW)'(lo_b) << (QW - 1);
      div_den = QW'(hi_b);
    end
    div_start = kick && !imm && (ph == PL_RATIO || ph == PL_STEP);
  end

  bx_divider #(.QW(QW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quot     (div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= LW'(1);
      n_len   <= LW'(1);
      cur_q   <= '0;
      src_b   <= '0;
      tgt_b   <= '0;
      ph      <= PL_IDLE;
      kick    <= 1'b0;
      waiting <= 1'b0;
      ratio   <= GAIN_ONE;
      step    <= '0;
    end else begin
      if (len_wr) len_q <= len_data;
      if (sel_wr) begin
        src_b   <= bright_tbl[int'(cur_q)*BW +: BW];
        tgt_b   <= bright_tbl[int'(sel_idx)*BW +: BW];
        cur_q   <= sel_idx;
        n_len   <= len_q;
        ph      <= PL_RATIO;
        kick    <= 1'b1;
        waiting <= 1'b0;
      end else begin
        kick <= 1'b0;
        if (kick && imm && ph == PL_RATIO) begin
          ph    <= PL_READY;
          ratio <= GAIN_ONE;
          step  <= '0;
        end
        if (div_start) waiting <= 1'b1;
        if (waiting && div_done) begin
          waiting <= 1'b0;
          if (ph == PL_RATIO) begin
            ratio <= div_q;
            ph    <= PL_STEP;
            kick  <= 1'b1;
          end else begin
            step <= div_q;
            ph   <= PL_READY;
          end
        end
        if (take) ph <= PL_IDLE;
      end
    end
  end

  assign ready = (ph == PL_READY);
  assign tgt   = cur_q;

  AST_RATIO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PL_STEP) |-> (ratio <= GAIN_ONE)); // R4
  AST_TAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ph == PL_READY)); // R10
endmodule

// File: rtl/bx_sequencer.sv
// Frame-level state: snap, start, per-frame ramp and final switch.
module bx_sequencer
  import bx_pkg::*;
#(
  parameter int LW = 8,
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              sel_wr,
  input  logic              static_mode,
  input  logic              ready,
  input  logic [IW-1:0]     tgt,
  input  logic [LW-1:0]     n_len,
  input  logic              dec,
  input  logic              imm,
  input  logic [GAIN_W-1:0] ratio,
  input  logic [GAIN_W-1:0] step,
  output logic              take,
  output logic [IW-1:0]     active_bin,
  output logic [GAIN_W-1:0] gain,
  output logic              busy
);
  logic          strobe, snap_pend, run, last;
  logic [IW-1:0] snap_bin;
  logic [LW-1:0] k_q;

  always_comb begin
    strobe = frame_start && !sel_wr;
    take   = strobe && !snap_pend && !run && busy && ready;
    last   = ({1'b0, k_q} + 1'b1) == {1'b0, n_len};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_bin <= '0;
      gain       <= GAIN_ONE;
      busy       <= 1'b0;
      snap_pend  <= 1'b0;
      snap_bin   <= '0;
      run        <= 1'b0;
      k_q        <= '0;
    end else if (sel_wr) begin
      busy <= 1'b1;
      run  <= 1'b0;
      if (busy) begin
        snap_pend <= 1'b1;
        snap_bin  <= tgt;
      end
    end else if (strobe) begin
      if (snap_pend) begin
        active_bin <= snap_bin;
        gain       <= GAIN_ONE;
        snap_pend  <= 1'b0;
      end else if (run) begin
        k_q <= k_q + 1'b1;
        if (last) begin
          gain <= GAIN_ONE;
          run  <= 1'b0;
          busy <= 1'b0;
          if (dec) active_bin <= tgt;
        end else begin
          gain <= dec ? gain - step : gain + step;
        end
      end else if (take) begin
        if (static_mode || imm) begin
          active_bin <= tgt;
          gain       <= GAIN_ONE;
          busy       <= 1'b0;
        end else begin
          k_q <= LW'(1);
          run <= 1'b1;
          if (dec) begin
            gain <= GAIN_ONE - step;
          end else begin
            active_bin <= tgt;
            gain       <= ratio;
          end
        end
      end
    end
  end

  AST_GAIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GAIN_ONE); // R5
  AST_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start || sel_wr) |=> ($stable(active_bin) && $stable(gain))); // R2
  AST_END_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (gain == GAIN_ONE)); // R11
  AST_STATIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && static_mode) |=> (!busy && gain == GAIN_ONE)); // R8
  AST_SNAP_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && snap_pend) |=> (busy && gain == GAIN_ONE)); // R9
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && run && dec && !last && !snap_pend) |=> $stable(active_bin)); // R4
endmodule

// File: rtl/bright_xfade.sv
module bright_xfade
  import bx_pkg::*;
#(
  parameter int BINS = 4,
  parameter int BW   = 16,
  parameter int LW   = 8,
  localparam int IW  = (BINS > 1) ? $clog2(BINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               len_wr,
  input  logic [LW-1:0]      len_data,
  input  logic               sel_wr,
  input  logic [IW-1:0]      sel_idx,
  input  logic [BINS*BW-1:0] bright_tbl,
  input  logic               static_mode,
  output logic [IW-1:0]      active_bin,
  output logic [GAIN_W-1:0]  gain,
  output logic               busy
);
  logic              take, ready, dec, imm;
  logic [IW-1:0]     tgt;
  logic [LW-1:0]     n_len;
  logic [GAIN_W-1:0] ratio, step;

  bx_planner #(.BINS(BINS), .BW(BW), .LW(LW), .IW(IW)) u_plan (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_wr),
    .sel_idx    (sel_idx),
    .len_wr     (len_wr),
    .len_data   (len_data),
    .bright_tbl (bright_tbl),
    .take       (take),
    .ready      (ready),
    .tgt        (tgt),
    .n_len      (n_len),
    .dec        (dec),
    .imm        (imm),
    .ratio      (ratio),
    .step       (step)
  );

  bx_sequencer #(.LW(LW), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .sel_wr      (sel_wr),
    .static_mode (static_mode),
    .ready       (ready),
    .tgt         (tgt),
    .n_len       (n_len),
    .dec         (dec),
    .imm         (imm),
    .ratio       (ratio),
    .step        (step),
    .take        (take),
    .active_bin  (active_bin),
    .gain        (gain),
    .busy        (busy)
  );
endmodule

// File: tb/bright_xfade_test.sv
module bright_xfade_test;
  localparam int BINS = 4, BW = 16, LW = 8, IW = 2;
  localparam int ONE = 32768;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n = 1'b0, frame_start = 1'b0, len_wr = 1'b0, sel_wr = 1'b0;
  logic               static_mode = 1'b0;
  logic [LW-1:0]      len_data = '0;
  logic [IW-1:0]      sel_idx = '0;
  logic [BINS*BW-1:0] bright_tbl;
  logic [IW-1:0]      active_bin;
  logic [15:0]        gain;
  logic               busy;

  int tbl [BINS] = '{40000, 10000, 25000, 40000};
  for (genvar g = 0; g < BINS; g++) begin : g_tbl
    assign bright_tbl[g*BW +: BW] = BW'(tbl[g]);
  end

  bright_xfade uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .len_wr(len_wr),
    .len_data(len_data), .sel_wr(sel_wr), .sel_idx(sel_idx),
    .bright_tbl(bright_tbl), .static_mode(static_mode),
    .active_bin(active_bin), .gain(gain), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  task automatic chk(string req, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Behavioural reference model
  int m_active, m_gain, m_tgt, m_snapbin, m_len, m_N, m_k, m_r, m_d, m_srcb, m_tgtb;
  bit m_busy, m_snap, m_pend, m_run, m_dec;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_gain = ONE; m_busy = 0; m_tgt = 0; m_snap = 0;
      m_pend = 0; m_run = 0; m_len = 1; m_N = 1; m_k = 0;
    end else begin
      if (sel_wr) begin
        if (m_busy) begin m_snap = 1; m_snapbin = m_tgt; end
        m_run = 0;
        m_srcb = tbl[m_tgt];
        m_tgtb = tbl[sel_idx];
        m_tgt = int'(sel_idx);
        m_N = m_len;
        m_pend = 1;
        m_busy = 1;
      end else if (frame_start) begin
        if (m_snap) begin
          m_active = m_snapbin; m_gain = ONE; m_snap = 0;
        end else if (m_run) begin
          m_k++;
          if (m_k == m_N) begin
            m_gain = ONE; m_active = m_tgt; m_run = 0; m_busy = 0;
          end else begin
            m_gain = m_dec ? ONE - m_d * m_k : m_r + m_d * (m_k - 1);
          end
        end else if (m_pend) begin
          m_pend = 0;
          if (static_mode || m_N <= 1 || m_srcb == m_tgtb) begin
            m_active = m_tgt; m_gain = ONE; m_busy = 0;
          end else begin
            longint lo, hi;
            m_dec = m_tgtb < m_srcb;
            lo = m_dec ? m_tgtb : m_srcb;
            hi = m_dec ? m_srcb : m_tgtb;
            m_r = int'((lo * 32768) / hi);
            m_d = m_dec ? (ONE - m_r) / m_N : (ONE - m_r) / (m_N - 1);
            m_k = 1; m_run = 1;
            if (m_dec) m_gain = ONE - m_d;
            else begin m_active = m_tgt; m_gain = m_r; end
          end
        end
      end
      if (len_wr) m_len = int'(len_data);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, int'(active_bin), m_active, "active_bin");
      chk(cur_req, int'(gain), m_gain, "gain");
      chk(cur_req, int'(busy), int'(m_busy), "busy");
    end
  end

  // Frame strobe every 64 cycles
  initial begin
    forever begin
      repeat (63) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
  end

  task automatic wait_frames(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (frame_start !== 1'b1) @(posedge clk);
    end
  endtask

  task automatic set_len(int v);
    @(negedge clk); len_wr = 1'b1; len_data = LW'(v);
    @(negedge clk); len_wr = 1'b0;
  endtask

  task automatic sel(int idx);
    wait_frames(1);
    @(negedge clk); sel_wr = 1'b1; sel_idx = IW'(idx);
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic sel_at_strobe(int idx);
    wait_frames(1);
    repeat (64) @(negedge clk);
    sel_wr = 1'b1; sel_idx = IW'(idx);
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic frame_then_sample(int n);
    wait_frames(n);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(64'd200000 * 20);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(active_bin), 0, "bin after reset");
    chk("R1", int'(gain), ONE, "gain after reset");
    chk("R1", int'(busy), 0, "busy after reset");
    cmp_on = 1'b1;

    // R4 decrease 0 -> 1 over 4 frames: r=8192, d=6144
    cur_req = "R4";
    set_len(4);
    sel(1);
    cur_req = "R2";
    chk("R2", int'(busy), 1, "busy on write");
    chk("R2", int'(active_bin), 0, "bin before frame");
    cur_req = "R4";
    frame_then_sample(1);
    chk("R4", int'(gain), 26624, "dec frame1 gain");
    chk("R4", int'(active_bin), 0, "dec frame1 bin");
    frame_then_sample(3);
    chk("R4", int'(active_bin), 1, "dec final bin");
    chk("R11", int'(busy), 0, "busy after final");
    chk("R11", int'(gain), ONE, "gain after final");

    // R5 increase 1 -> 2: r=13107, d=6553
    cur_req = "R5";
    sel(2);
    cur_req = "R10";
    frame_then_sample(1);
    chk("R5", int'(active_bin), 2, "inc frame1 bin");
    chk("R5", int'(gain), 13107, "inc frame1 gain");
    cur_req = "R5";
    frame_then_sample(3);
    chk("R5", int'(gain), ONE, "inc final gain");

    // R3 length latched at select
    cur_req = "R3";
    sel(0);
    frame_then_sample(1);
    set_len(2);
    frame_then_sample(1);
    chk("R3", int'(busy), 1, "old length still in force");
    wait_frames(3);
    sel(1);
    frame_then_sample(2);
    chk("R3", int'(active_bin), 1, "new length applied");
    chk("R3", int'(busy), 0, "new length done");

    // R6 lengths 1 and 0
    cur_req = "R6";
    set_len(1);
    sel(2);
    frame_then_sample(1);
    chk("R6", int'(active_bin), 2, "len1 immediate");
    set_len(0);
    sel(0);
    frame_then_sample(1);
    chk("R6", int'(active_bin), 0, "len0 immediate");
    chk("R6", int'(gain), ONE, "len0 gain");

    // R7 equal brightness 0 -> 3
    cur_req = "R7";
    set_len(5);
    sel(3);
    frame_then_sample(1);
    chk("R7", int'(active_bin), 3, "equal immediate");
    chk("R7", int'(busy), 0, "equal busy");

    // R8 static mode
    cur_req = "R8";
    static_mode = 1'b1;
    set_len(8);
    sel(1);
    frame_then_sample(1);
    chk("R8", int'(active_bin), 1, "static immediate");
    chk("R8", int'(gain), ONE, "static gain");
    static_mode = 1'b0;

    // R9 mid-ramp select
    cur_req = "R9";
    set_len(1);
    sel(0);
    wait_frames(1);
    set_len(6);
    sel(2);
    frame_then_sample(1);
    chk("R9", int'(gain), 30720, "first ramp frame");
    sel(0);
    frame_then_sample(1);
    chk("R9", int'(active_bin), 2, "snap bin");
    chk("R9", int'(gain), ONE, "snap gain");
    chk("R9", int'(busy), 1, "busy after snap");
    frame_then_sample(1);
    chk("R9", int'(active_bin), 0, "restart bin");
    chk("R9", int'(gain), 20480, "restart gain");
    wait_frames(6);

    // R10 strobe coinciding with a write is not a frame
    cur_req = "R10";
    set_len(2);
    sel_at_strobe(1);
    chk("R10", int'(gain), ONE, "coincident strobe ignored");
    frame_then_sample(1);
    chk("R10", int'(gain), 20480, "first counted frame");
    chk("R10", int'(active_bin), 0, "first counted frame bin");
    frame_then_sample(1);
    chk("R10", int'(active_bin), 1, "second frame bin");
    wait_frames(1);
    @(negedge clk);
    cmp_on = 1'b0;
    finish_run();
  end
endmodule